// File: doc/BRIEF.md
# Max-Log-MAP Trellis Step Unit

This block is the arithmetic core of a soft-input soft-output decoder for the eight-state recursive systematic code with feedback polynomial 1+D^2+D^3 and feed-forward polynomial 1+D+D^3. For one trellis step it takes three signed soft values: systematic, parity and a-priori. From them it forms the branch costs of the four input/parity combinations. It then performs one add-compare-select recursion over the eight states, forward or backward, and renormalizes the resulting metric vector. In the same step it computes the a-posteriori log-likelihood ratio from a supplied forward vector and a supplied backward vector.

A surrounding controller owns the metric storage. It feeds the unit one step per valid cycle and writes back the returned vector. For each step it also presents the forward metrics of step k and the backward metrics of step k+1, so that the ratio for step k comes out with the recursion result. A first-step flag replaces the recursion operand with the start vector. This removes the need to store an initial vector at the start of a forward pass or at the terminated end of a backward pass.

Top module: `mlm_step_unit`

## Requirements
- R1: While rst_n is low, out_valid is 0, metric_out is all zeros and llr_out is 0.
- R2: Soft values are two's complement, and a positive value favours bit 1. With L = sys_in + apr_in, the cost of a branch with input u and parity p is (u ? max(-L,0) : max(L,0)) + (p ? max(-par_in,0) : max(par_in,0)).
- R3: State index bit 2 is the newest register bit, bits 1 and 0 the older ones. Input u at state s gives f = u^s[1]^s[0], parity f^s[2]^s[0] and next state {f,s[2],s[1]}. With dir_bwd=0, each new metric is the minimum over the two incoming transitions of the old metric of the source state plus the branch cost.
- R4: With dir_bwd=1, each new metric of state s is the minimum over u of the branch cost plus the backward metric of the next state.
- R5: The new vector has its minimum subtracted from every entry, so at least one entry is 0. Any entry above 2^MW-1 is clamped to 2^MW-1.
- R6: With step_first=1, the operand of the selected direction is replaced by the start vector: state 0 is 0 and every other state is 2^MW-1. The replaced operand is used for both the recursion and the ratio.
- R7: llr_out equals the minimum over the eight u=1 transitions of (forward[s] + cost + backward[next]) minus the same minimum over the eight u=0 transitions. A negative value favours 1.
- R8: Every cycle with in_valid=1 produces exactly one result with out_valid=1 in the following cycle.
- R9: In cycles without in_valid, metric_out and llr_out keep their values whatever the other inputs do, and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One trellis step is presented this cycle |
| dir_bwd | input | 1 | 0: forward recursion, 1: backward recursion |
| step_first | input | 1 | Substitute the start vector for the recursion operand |
| sys_in | input | SW | Signed systematic soft value |
| par_in | input | SW | Signed parity soft value |
| apr_in | input | SW | Signed a-priori soft value |
| fwd_metric_in | input | 8*MW | Forward metrics of step k, state i at bits [i*MW +: MW] |
| bwd_metric_in | input | 8*MW | Backward metrics of step k+1, same packing |
| out_valid | output | 1 | Result valid |
| metric_out | output | 8*MW | Updated, normalized metric vector, same packing |
| llr_out | output | MW+3 | Signed a-posteriori log-likelihood ratio |

## Verification
The hardest behaviour to reach is the clamp at the top of the metric range. Ordinary decoding streams keep metrics small, and the clamp only acts when unreachable states sit at the ceiling next to a state at zero and large branch costs push the sums past the limit. The stimulus drives vectors that are all at the ceiling except one entry, together with extreme soft values. It also issues first-step commands carrying deliberately wrong operand vectors, and checks chained forward and backward passes against the bench's own trellis model, fed back step after step without a gap.

// File: rtl/mlm_pkg.sv
package mlm_pkg;

  localparam int NSTATE = 8;

  // feedback bit of the recursive encoder for input u at state st
  function automatic logic trel_fb(input logic [2:0] st, input logic u);
    return u ^ st[1] ^ st[0];
  endfunction

  function automatic logic [2:0] trel_next(input logic [2:0] st, input logic u);
    return {trel_fb(st, u), st[2], st[1]};
  endfunction

  function automatic logic trel_par(input logic [2:0] st, input logic u);
    return trel_fb(st, u) ^ st[2] ^ st[0];
  endfunction

  // j-th predecessor of state ns
  function automatic logic [2:0] trel_pred(input logic [2:0] ns, input logic j);
    return {ns[1], ns[0], j};
  endfunction

  // input bit that drives the j-th predecessor into ns
  function automatic logic trel_pred_in(input logic [2:0] ns, input logic j);
    logic [2:0] ps;
    ps = trel_pred(ns, j);
    return ns[2] ^ ps[1] ^ ps[0];
  endfunction

endpackage

// File: rtl/mlm_branch.sv
module mlm_branch #(
  parameter int SW = 6
) (
  input  logic signed [SW-1:0]  sys_i,
  input  logic signed [SW-1:0]  par_i,
  input  logic signed [SW-1:0]  apr_i,
  output logic [3:0][SW+1:0]    gamma_o
);

  logic signed [SW+1:0] lsum;
  logic signed [SW+1:0] pext;
  logic [SW+1:0] cu0, cu1, cp0, cp1;

  assign lsum = (SW+2)'(sys_i) + (SW+2)'(apr_i);
  assign pext = (SW+2)'(par_i);

  // costs offset so the agreeing decision is free
  always_comb begin
    cu0 = (lsum > 0) ? lsum  : '0;
    cu1 = (lsum < 0) ? -lsum : '0;
    cp0 = (pext > 0) ? pext  : '0;
    cp1 = (pext < 0) ? -pext : '0;
    gamma_o[0] = cu0 + cp0;
    gamma_o[1] = cu0 + cp1;
    gamma_o[2] = cu1 + cp0;
    gamma_o[3] = cu1 + cp1;
  end

endmodule

// File: rtl/mlm_acs.sv
module mlm_acs import mlm_pkg::*; #(
  parameter int MW = 10,
  parameter int GW = 8
) (
  input  logic                         dir_bwd,
  input  logic [NSTATE-1:0][MW-1:0]    metric_i,
  input  logic [3:0][GW-1:0]           gamma_i,
  output logic [NSTATE-1:0][MW-1:0]    metric_o
);

  localparam logic [MW:0] SATV = {1'b0, {MW{1'b1}}};

  logic [NSTATE-1:0][MW:0] raw;
  logic [MW:0] mn;

  for (genvar s = 0; s < NSTATE; s++) begin : g_st
    localparam logic [2:0] FP0 = trel_pred(3'(s), 1'b0);
    localparam logic [2:0] FP1 = trel_pred(3'(s), 1'b1);
    localparam logic       FU0 = trel_pred_in(3'(s), 1'b0);
    localparam logic       FU1 = trel_pred_in(3'(s), 1'b1);
    localparam logic       FQ0 = trel_par(FP0, FU0);
    localparam logic       FQ1 = trel_par(FP1, FU1);
    localparam logic [2:0] BN0 = trel_next(3'(s), 1'b0);
    localparam logic [2:0] BN1 = trel_next(3'(s), 1'b1);
    localparam logic       BQ0 = trel_par(3'(s), 1'b0);
    localparam logic       BQ1 = trel_par(3'(s), 1'b1);

    logic [MW:0] c0, c1;

    assign c0 = dir_bwd
      ? (MW+1)'(metric_i[BN0]) + (MW+1)'(gamma_i[{1'b0, BQ0}])
      : (MW+1)'(metric_i[FP0]) + (MW+1)'(gamma_i[{FU0, FQ0}]);
    assign c1 = dir_bwd
      ? (MW+1)'(metric_i[BN1]) + (MW+1)'(gamma_i[{1'b1, BQ1}])
      : (MW+1)'(metric_i[FP1]) + (MW+1)'(gamma_i[{FU1, FQ1}]);
    assign raw[s] = (c1 < c0) ? c1 : c0;
  end

  // normalize to the vector minimum, then clamp to the metric range
  always_comb begin
    mn = raw[0];
    for (int i = 1; i < NSTATE; i++) begin
      if (raw[i] < mn) mn = raw[i];
    end
    for (int i = 0; i < NSTATE; i++) begin
      if ((raw[i] - mn) > SATV) metric_o[i] = '1;
      else                      metric_o[i] = MW'(raw[i] - mn);
    end
  end

endmodule

// File: rtl/mlm_llr.sv
module mlm_llr import mlm_pkg::*; #(
  parameter int MW = 10,
  parameter int GW = 8,
  parameter int LW = MW + 3
) (
  input  logic [NSTATE-1:0][MW-1:0]  alpha_i,
  input  logic [NSTATE-1:0][MW-1:0]  beta_i,
  input  logic [3:0][GW-1:0]         gamma_i,
  output logic signed [LW-1:0]       llr_o
);

  localparam int PW = MW + 2;

  logic [NSTATE-1:0][PW-1:0] path0, path1;
  logic [PW-1:0] mn0, mn1;

  for (genvar s = 0; s < NSTATE; s++) begin : g_path
    localparam logic [2:0] N0 = trel_next(3'(s), 1'b0);
    localparam logic [2:0] N1 = trel_next(3'(s), 1'b1);
    localparam logic       Q0 = trel_par(3'(s), 1'b0);
    localparam logic       Q1 = trel_par(3'(s), 1'b1);

    assign path0[s] = PW'(alpha_i[s]) + PW'(gamma_i[{1'b0, Q0}]) + PW'(beta_i[N0]);
    assign path1[s] = PW'(alpha_i[s]) + PW'(gamma_i[{1'b1, Q1}]) + PW'(beta_i[N1]);
  end

  always_comb begin
    mn0 = path0[0];
    mn1 = path1[0];
    for (int i = 1; i < NSTATE; i++) begin
      if (path0[i] < mn0) mn0 = path0[i];
      if (path1[i] < mn1) mn1 = path1[i];
    end
    llr_o = $signed({1'b0, mn1}) - $signed({1'b0, mn0});
  end

endmodule

// File: rtl/mlm_step_unit.sv
module mlm_step_unit import mlm_pkg::*; #(
  parameter  int SW = 6,
  parameter  int MW = 10,
  localparam int LW = MW + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     dir_bwd,
  input  logic                     step_first,
  input  logic signed [SW-1:0]     sys_in,
  input  logic signed [SW-1:0]     par_in,
  input  logic signed [SW-1:0]     apr_in,
  input  logic [NSTATE*MW-1:0]     fwd_metric_in,
  input  logic [NSTATE*MW-1:0]     bwd_metric_in,
  output logic                     out_valid,
  output logic [NSTATE*MW-1:0]     metric_out,
  output logic signed [LW-1:0]     llr_out
);

  localparam int GW = SW + 2;

  logic [NSTATE-1:0][MW-1:0] start_vec, fwd_eff, bwd_eff, acs_in, acs_out;
  logic [NSTATE-1:0][MW-1:0] metric_d, metric_q;
  logic [3:0][GW-1:0]        gamma;
  logic signed [LW-1:0]      llr_w, llr_d, llr_q;
  logic                      vld_d, vld_q;

  always_comb begin
    start_vec    = '1;
    start_vec[0] = '0;
  end

  assign fwd_eff = (step_first && !dir_bwd) ? start_vec : fwd_metric_in;
  assign bwd_eff = (step_first &&  dir_bwd) ? start_vec : bwd_metric_in;
  assign acs_in  = dir_bwd ? bwd_eff : fwd_eff;

  mlm_branch #(.SW(SW)) i_branch (
    .sys_i   (sys_in),
    .par_i   (par_in),
    .apr_i   (apr_in),
    .gamma_o (gamma)
  );

  mlm_acs #(.MW(MW), .GW(GW)) i_acs (
    .dir_bwd  (dir_bwd),
    .metric_i (acs_in),
    .gamma_i  (gamma),
    .metric_o (acs_out)
  );

  mlm_llr #(.MW(MW), .GW(GW), .LW(LW)) i_llr (
    .alpha_i (fwd_eff),
    .beta_i  (bwd_eff),
    .gamma_i (gamma),
    .llr_o   (llr_w)
  );

  // next state: capture only on a valid step
  always_comb begin
    vld_d    = in_valid;
    metric_d = metric_q;
    llr_d    = llr_q;
    if (in_valid) begin
      metric_d = acs_out;
      llr_d    = llr_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      metric_q <= '0;
      llr_q    <= '0;
    end else begin
      vld_q    <= vld_d;
      metric_q <= metric_d;
      llr_q    <= llr_d;
    end
  end

  assign out_valid  = vld_q;
  assign metric_out = metric_q;
  assign llr_out    = llr_q;

endmodule

// File: rtl/mlm_step_unit_chk.sv
module mlm_step_unit_chk import mlm_pkg::*; #(
  parameter int MW = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   dir_bwd,
  input logic                   step_first,
  input logic                   out_valid,
  input logic [NSTATE*MW-1:0]   metric_out,
  input logic [MW+2:0]          llr_out
);

  logic any_zero;

  always_comb begin
    any_zero = 1'b0;
    for (int i = 0; i < NSTATE; i++) begin
      if (metric_out[i*MW +: MW] == '0) any_zero = 1'b1;
    end
  end

  a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_outputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(metric_out) && $stable(llr_out)));

  a_r5_min_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> any_zero);

  // from the start vector only states 0 and 4 are reachable going forward
  a_r6_fwd_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_first && !dir_bwd) |=>
      (metric_out[0 +: MW] == '0 || metric_out[4*MW +: MW] == '0));

  // going backward from the terminated end only states 0 and 1 are reachable
  a_r6_bwd_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && step_first && dir_bwd) |=>
      (metric_out[0 +: MW] == '0 || metric_out[MW +: MW] == '0));

endmodule

bind mlm_step_unit mlm_step_unit_chk #(.MW(MW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .dir_bwd    (dir_bwd),
  .step_first (step_first),
  .out_valid  (out_valid),
  .metric_out (metric_out),
  .llr_out    (llr_out)
);

// File: tb/test_mlm_step_unit.sv
module test_mlm_step_unit;
  localparam int SW = 6;
  localparam int MW = 10;
  localparam int NS = 8;
  localparam int VW = NS * MW;
  localparam int LW = MW + 3;
  localparam int TOP = (1 << MW) - 1;

  logic clk, rst_n, in_valid, dir_bwd, step_first;
  logic signed [SW-1:0] sys_in, par_in, apr_in;
  logic [VW-1:0] fwd_metric_in, bwd_metric_in, metric_out;
  logic out_valid;
  logic signed [LW-1:0] llr_out;

  mlm_step_unit #(.SW(SW), .MW(MW)) i_mlm_step_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_bwd(dir_bwd),
    .step_first(step_first), .sys_in(sys_in), .par_in(par_in), .apr_in(apr_in),
    .fwd_metric_in(fwd_metric_in), .bwd_metric_in(bwd_metric_in),
    .out_valid(out_valid), .metric_out(metric_out), .llr_out(llr_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [VW-1:0] m;
    int            l;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int soft_rand();
    return int'(rnd() % 64) - 32;
  endfunction

  function automatic logic [VW-1:0] vec_rand();
    logic [VW-1:0] v;
    for (int i = 0; i < NS; i++) v[i*MW +: MW] = MW'(rnd() % 1024);
    return v;
  endfunction

  // cost of deciding bit b against soft value x (R2)
  function automatic int cost(input int b, input int x);
    if (b != 0) return (x < 0) ? -x : 0;
    return (x > 0) ? x : 0;
  endfunction

  function automatic int enc_fb(input int st, input int u);
    return u ^ ((st >> 1) & 1) ^ (st & 1);
  endfunction

  function automatic int enc_next(input int st, input int u);
    return (enc_fb(st, u) << 2) | (st >> 1);
  endfunction

  function automatic int enc_par(input int st, input int u);
    return enc_fb(st, u) ^ ((st >> 2) & 1) ^ (st & 1);
  endfunction

  function automatic logic [VW-1:0] start_v();
    logic [VW-1:0] v;
    v = '1;
    v[0 +: MW] = '0;
    return v;
  endfunction

  function automatic logic [VW-1:0] ref_vec(input bit bwd, input logic [VW-1:0] vin,
                                            input int l, input int yp);
    int m[NS];
    int n[NS];
    int mn, c, ns, d;
    logic [VW-1:0] r;
    for (int i = 0; i < NS; i++) begin
      m[i] = int'(vin[i*MW +: MW]);
      n[i] = 1 << 30;
    end
    for (int s = 0; s < NS; s++) begin
      for (int u = 0; u < 2; u++) begin
        ns = enc_next(s, u);
        c = cost(u, l) + cost(enc_par(s, u), yp);
        if (!bwd) begin
          if (m[s] + c < n[ns]) n[ns] = m[s] + c;
        end else begin
          if (m[ns] + c < n[s]) n[s] = m[ns] + c;
        end
      end
    end
    mn = n[0];
    for (int i = 1; i < NS; i++) if (n[i] < mn) mn = n[i];
    for (int i = 0; i < NS; i++) begin
      d = n[i] - mn;
      if (d > TOP) d = TOP;
      r[i*MW +: MW] = MW'(d);
    end
    return r;
  endfunction

  function automatic int ref_llr(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                 input int l, input int yp);
    int best[2];
    int v, ns;
    best[0] = 1 << 30;
    best[1] = 1 << 30;
    for (int s = 0; s < NS; s++) begin
      for (int u = 0; u < 2; u++) begin
        ns = enc_next(s, u);
        v = int'(a[s*MW +: MW]) + cost(u, l) + cost(enc_par(s, u), yp)
          + int'(b[ns*MW +: MW]);
        if (v < best[u]) best[u] = v;
      end
    end
    return best[1] - best[0];
  endfunction

  // driver: present one step and push its expected result
  task automatic step(input bit bwd, input bit first, input int ys, input int yp,
                      input int la, input logic [VW-1:0] fa, input logic [VW-1:0] fb,
                      input string tag, output logic [VW-1:0] nxt);
    exp_t e;
    logic [VW-1:0] a_e, b_e;
    @(negedge clk);
    in_valid = 1'b1;
    dir_bwd = bwd;
    step_first = first;
    sys_in = SW'(ys);
    par_in = SW'(yp);
    apr_in = SW'(la);
    fwd_metric_in = fa;
    bwd_metric_in = fb;
    a_e = (first && !bwd) ? start_v() : fa;
    b_e = (first &&  bwd) ? start_v() : fb;
    e.m = ref_vec(bwd, bwd ? b_e : a_e, ys + la, yp);
    e.l = ref_llr(a_e, b_e, ys + la, yp);
    e.tag = tag;
    q.push_back(e);
    nxt = e.m;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "out_valid without a step", "1", "0");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(metric_out == e.m, e.tag, "metric vector",
              $sformatf("%0h", metric_out), $sformatf("%0h", e.m));
        check(int'(llr_out) == e.l, "R7", "llr",
              $sformatf("%0d", int'(llr_out)), $sformatf("%0d", e.l));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] va, vb, nx, held_m;
    int held_l, u, st, ys, yp;
    rst_n = 1'b0;
    in_valid = 1'b0;
    dir_bwd = 1'b0;
    step_first = 1'b0;
    sys_in = '0;
    par_in = '0;
    apr_in = '0;
    fwd_metric_in = '0;
    bwd_metric_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", $sformatf("%0b", out_valid), "0");
    check(metric_out == '0, "R1", "metric_out in reset", $sformatf("%0h", metric_out), "0");
    check(llr_out == '0, "R1", "llr_out in reset", $sformatf("%0d", llr_out), "0");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: branch costs on first steps with hand-picked soft values
    step(1'b0, 1'b1, 10, -7, 5, vec_rand(), vec_rand(), "R2", nx);
    step(1'b0, 1'b1, -20, 13, 4, vec_rand(), vec_rand(), "R2", nx);
    step(1'b1, 1'b1, -32, -32, -32, vec_rand(), vec_rand(), "R2", nx);
    // R6: start vector substituted despite wrong operand vectors
    step(1'b0, 1'b1, 3, 9, -6, '0, vec_rand(), "R6", nx);
    step(1'b1, 1'b1, -11, 2, 8, vec_rand(), '0, "R6", nx);

    // R3: forward chain over an encoded sequence, back to back
    st = 0;
    va = start_v();
    for (int k = 0; k < 12; k++) begin
      u = int'(rnd() % 2);
      ys = (u != 0 ? 12 : -12) + int'(rnd() % 17) - 8;
      yp = (enc_par(st, u) != 0 ? 10 : -10) + int'(rnd() % 13) - 6;
      step(1'b0, k == 0, ys, yp, int'(rnd() % 21) - 10, va, vec_rand(), "R3", nx);
      va = nx;
      st = enc_next(st, u);
    end

    // R4: backward chain
    vb = start_v();
    for (int k = 0; k < 12; k++) begin
      step(1'b1, k == 0, soft_rand(), soft_rand(), soft_rand(), vec_rand(), vb, "R4", nx);
      vb = nx;
    end

    // R3/R4: alternating directions with arbitrary vectors
    for (int k = 0; k < 20; k++) begin
      step(k[0], 1'b0, soft_rand(), soft_rand(), soft_rand(), vec_rand(), vec_rand(),
           k[0] ? "R4" : "R3", nx);
    end

    // R5: clamp at the top of the range
    va = '1;
    va[3*MW +: MW] = '0;
    step(1'b0, 1'b0, 31, 31, 31, va, va, "R5", nx);
    step(1'b1, 1'b0, -32, -32, -32, va, va, "R5", nx);
    step(1'b0, 1'b0, -32, 31, 31, '1, '1, "R5", nx);
    step(1'b1, 1'b0, 31, -32, -32, va, '1, "R5", nx);

    // R9: hold while idle with other inputs moving
    step(1'b0, 1'b0, 7, -5, 2, vec_rand(), vec_rand(), "R3", nx);
    idle(1);
    held_m = metric_out;
    held_l = int'(llr_out);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      dir_bwd = ~dir_bwd;
      step_first = ~step_first;
      sys_in = SW'(soft_rand());
      par_in = SW'(soft_rand());
      apr_in = SW'(soft_rand());
      fwd_metric_in = vec_rand();
      bwd_metric_in = vec_rand();
    end
    @(negedge clk);
    check(metric_out == held_m, "R9", "metric held",
          $sformatf("%0h", metric_out), $sformatf("%0h", held_m));
    check(int'(llr_out) == held_l, "R9", "llr held",
          $sformatf("%0d", int'(llr_out)), $sformatf("%0d", held_l));
    check(out_valid == 1'b0, "R9", "out_valid idle", $sformatf("%0b", out_valid), "0");

    idle(3);
    check(q.size() == 0, "R8", "results outstanding", $sformatf("%0d", q.size()), "0");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule